// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects the event flags of a serial-bus link-layer controller and presents them to a host CPU. Each flag lives in a 32-bit status register, and a 32-bit enable register sits next to it. Logic elsewhere in the controller raises one-cycle pulses on `evt_set`, and each pulse latches its flag. Software reads the flags, clears them by writing ones, and chooses through the enable register which flags may raise the interrupt.

Bit 31 of the status register is a read-only summary. It is set whenever any flag in bits 30..0 is set and also enabled. Bit 31 of the enable register is a global gate for the active-low `irq_n` pin, and that pin is registered. When the `test_rw` input is high, the status register stops behaving as clear-on-write and becomes ordinary storage, so diagnostics can force any flag. One flag is sealed: it records an error condition, and writing one to it does not clear it.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status register reads 0x0000_0000, the enable register reads 0x0000_0000, and `irq_n` is 1.
- R2: The status register decodes at byte offset 0x0C and the enable register at byte offset 0x10. Any other offset reads as 0, and a write to any other offset changes neither register.
- R3: With `test_rw` = 0, writing 1 to a status bit at offset 0x0C clears that bit after the clock edge. Writing 0 leaves the bit unchanged.
- R4: With `test_rw` = 0, a write of 1 does not clear the sealed error flag at bit 21, and it has no effect on the summary bit 31.
- R5: With `test_rw` = 1, a write at offset 0x0C loads every implemented status bit in 30..0, including bit 21, with the written value.
- R6: An `evt_set` pulse on an implemented bit sets that status bit at the next clock edge. If the same bit is also being cleared or written to 0 in that cycle, the set still takes effect.
- R7: The implemented status bits are those in 0xFFFB_8FC0. All other positions always read 0, and writes and event pulses do not change them.
- R8: The enable register at offset 0x10 stores all 32 written bits and reads them back unchanged.
- R9: Status bit 31 reads as the OR of (status AND enable) over bits 30..0. It changes in the same cycle as the registers it depends on.
- R10: `irq_n` is 0 exactly when, one clock earlier, the summary was 1 and enable bit 31 was 1. Otherwise `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_rw | input | 1 | 1 = status register is plain read/write |
| evt_set | input | 32 | One-cycle event pulses, one per status bit |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe for the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
The embedded properties are checked on every cycle. They cover four points: in normal mode no status bit rises without an event pulse; an event pulse always lands even under a clear; the sealed flag survives normal writes; and the enable register and the test-mode load take the written data. They also cover both directions of the registered interrupt pin. The address map, the read-as-zero behaviour of unused positions and stray offsets, and the same-cycle value of the summary bit can only be seen through the bench's read-back scenarios. The same holds for the one-clock lag of `irq_n` behind a new event.

// File: rtl/isc_pkg.sv
package isc_pkg;

   // Which register a bus access selects
   typedef enum logic [1:0] {
      ISC_SEL_NONE = 2'd0,
      ISC_SEL_STAT = 2'd1,
      ISC_SEL_MASK = 2'd2
   } isc_sel_e;

   // One-hot vector with a single bit set at position pos
   function automatic logic [63:0] isc_bit(input int unsigned pos);
      logic [63:0] v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/isc_decode.sv
module isc_decode
   import isc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STAT_OFFS = 'h0C,
   parameter int unsigned MASK_OFFS = 'h10
) (
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] stat_view,
   input  logic [DATA_W-1:0] mask_view,
   output logic              stat_we,
   output logic              mask_we,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFS);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFFS);

   if (STAT_OFFS == MASK_OFFS) begin : g_bad_map
      $error("isc_decode: status and enable offsets collide");
   end
   if ((STAT_OFFS >> ADDR_W) != 0 || (MASK_OFFS >> ADDR_W) != 0) begin : g_bad_width
      $error("isc_decode: offset does not fit the address width");
   end

   isc_sel_e sel;

   always_comb begin
      if (reg_addr == STAT_A)      sel = ISC_SEL_STAT;
      else if (reg_addr == MASK_A) sel = ISC_SEL_MASK;
      else                         sel = ISC_SEL_NONE;
   end

   assign stat_we = reg_we && (sel == ISC_SEL_STAT);
   assign mask_we = reg_we && (sel == ISC_SEL_MASK);

   always_comb begin
      unique case (sel)
         ISC_SEL_STAT: rdata = stat_view;
         ISC_SEL_MASK: rdata = mask_view;
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
   parameter int unsigned     DATA_W    = 32,
   parameter logic [DATA_W-1:0] LIVE_MASK = 32'hFFFB_8FC0,
   parameter int unsigned     SEAL_BIT  = 21,
   parameter int unsigned     SUM_BIT   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_rw,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] evt_set,
   output logic [DATA_W-1:0] stat_q
);

   // Bits that hold real storage: implemented and not the summary position
   localparam logic [DATA_W-1:0] SUM_M = DATA_W'(isc_pkg::isc_bit(SUM_BIT));
   localparam logic [DATA_W-1:0] KEEP  = LIVE_MASK & ~SUM_M;

   logic test_wr;
   logic norm_wr;
   assign test_wr = we && test_rw;
   assign norm_wr = we && !test_rw;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (KEEP[i]) begin : g_live
         logic nxt;
         if (i == SEAL_BIT) begin : g_sealed
            // Only a test-mode write can lower the sealed flag
            always_comb begin
               if (test_wr) nxt = wdata[i];
               else         nxt = stat_q[i];
            end
         end else begin : g_w1c
            always_comb begin
               if (test_wr)                  nxt = wdata[i];
               else if (norm_wr && wdata[i]) nxt = 1'b0;
               else                          nxt = stat_q[i];
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= nxt | evt_set[i];
         end
      end else begin : g_tie
         assign stat_q[i] = 1'b0;
      end
   end

   logic unused_inputs;
   assign unused_inputs = ^{evt_set & ~KEEP, wdata & ~KEEP};

   // R3
   no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !test_wr |=> ((stat_q & ~$past(stat_q) & ~$past(evt_set)) == '0));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_set & KEEP)) |=> ((stat_q & $past(evt_set & KEEP)) == $past(evt_set & KEEP)));

   // R4
   seal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_wr && stat_q[SEAL_BIT]) |=> stat_q[SEAL_BIT]);

   // R5
   test_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_wr |=> (stat_q == (($past(wdata) | $past(evt_set)) & KEEP)));

endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '0;
      else if (we) mask_q <= wdata;
   end

   // R8
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SUM_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] mask_q,
   output logic              summary,
   output logic              irq_n
);

   localparam logic [DATA_W-1:0] BODY = ~DATA_W'(isc_pkg::isc_bit(SUM_BIT));

   logic [DATA_W-1:0] armed;
   assign armed   = stat_q & mask_q & BODY;
   assign summary = |armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= !(summary && mask_q[SUM_BIT]);
   end

   // R10
   irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(stat_q & mask_q & BODY)) && mask_q[SUM_BIT]) |=> !irq_n);

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_q[SUM_BIT] || ((stat_q & mask_q & BODY) == '0)) |=> irq_n);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       STAT_OFFS = 'h0C,
   parameter int unsigned       MASK_OFFS = 'h10,
   parameter logic [DATA_W-1:0] LIVE_MASK = 32'hFFFB_8FC0,
   parameter int unsigned       SEAL_BIT  = 21,
   parameter int unsigned       SUM_BIT   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_rw,
   input  logic [DATA_W-1:0] evt_set,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_n
);

   if (SUM_BIT >= DATA_W || SEAL_BIT >= DATA_W) begin : g_bad_pos
      $error("irq_status_ctrl: bit position outside the data width");
   end
   if (SEAL_BIT == SUM_BIT) begin : g_bad_seal
      $error("irq_status_ctrl: sealed flag cannot be the summary bit");
   end
   if (DATA_W > 64) begin : g_bad_width
      $error("irq_status_ctrl: data width limited to 64");
   end

   logic              stat_we;
   logic              mask_we;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] stat_view;
   logic              summary;

   isc_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .STAT_OFFS(STAT_OFFS),
      .MASK_OFFS(MASK_OFFS)
   ) u_dec (
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .stat_view(stat_view),
      .mask_view(mask_q),
      .stat_we  (stat_we),
      .mask_we  (mask_we),
      .rdata    (reg_rdata)
   );

   isc_status_reg #(
      .DATA_W   (DATA_W),
      .LIVE_MASK(LIVE_MASK),
      .SEAL_BIT (SEAL_BIT),
      .SUM_BIT  (SUM_BIT)
   ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .test_rw(test_rw),
      .we     (stat_we),
      .wdata  (reg_wdata),
      .evt_set(evt_set),
      .stat_q (stat_q)
   );

   isc_mask_reg #(
      .DATA_W(DATA_W)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .wdata (reg_wdata),
      .mask_q(mask_q)
   );

   isc_irq_out #(
      .DATA_W (DATA_W),
      .SUM_BIT(SUM_BIT)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_q (stat_q),
      .mask_q (mask_q),
      .summary(summary),
      .irq_n  (irq_n)
   );

   // Summary replaces the (always empty) storage slot at its position
   always_comb begin
      stat_view          = stat_q;
      stat_view[SUM_BIT] = summary;
   end

endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

   localparam int          CLK_PERIOD = 10;
   localparam logic [7:0]  A_STAT = 8'h0C;
   localparam logic [7:0]  A_MASK = 8'h10;
   localparam logic [31:0] LIVE   = 32'hFFFB_8FC0;
   localparam logic [31:0] BODY   = LIVE & 32'h7FFF_FFFF;
   localparam logic [31:0] SEAL_M = 32'h0020_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        test_rw = 1'b0;
   logic [31:0] evt_set = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_n;

   int checks = 0;
   int errors = 0;

   logic [31:0] stat_m = '0;
   logic [31:0] mask_m = '0;
   logic        irq_m  = 1'b1;

   irq_status_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_rw  (test_rw),
      .evt_set  (evt_set),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq_n    (irq_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic sum_of(logic [31:0] s, logic [31:0] m);
      return |(s & m & 32'h7FFF_FFFF);
   endfunction

   function automatic logic [31:0] stat_read(logic [31:0] s, logic [31:0] m);
      return s | {sum_of(s, m), 31'd0};
   endfunction

   function automatic logic [31:0] next_stat(logic [31:0] s, logic we, logic [7:0] a,
                                             logic [31:0] wd, logic [31:0] ev, logic tm);
      logic [31:0] n;
      n = s;
      if (we && a == A_STAT) n = tm ? wd : (s & ~(wd & ~SEAL_M));
      return (n | ev) & BODY;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One clock cycle of stimulus, with the model advanced at the edge
   task automatic step(logic we, logic [7:0] a, logic [31:0] wd, logic [31:0] ev, logic tm);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = wd; evt_set = ev; test_rw = tm;
      @(posedge clk);
      irq_m  = !(sum_of(stat_m, mask_m) && mask_m[31]);
      stat_m = next_stat(stat_m, we, a, wd, ev, tm);
      if (we && a == A_MASK) mask_m = wd;
      #1;
      reg_we = 1'b0; evt_set = '0; test_rw = 1'b0;
   endtask

   task automatic check_all(string tag);
      reg_addr = A_STAT; #1;
      chk({tag, " status"}, reg_rdata, stat_read(stat_m, mask_m));
      reg_addr = A_MASK; #1;
      chk({tag, " enable"}, reg_rdata, mask_m);
      chk({tag, " irq_n"}, {31'd0, irq_n}, {31'd0, irq_m});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_1394));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset values
      check_all("R1");

      // R8 enable register stores all bits
      step(1, A_MASK, 32'h8000_0040, 0, 0);
      check_all("R8");

      // R6 event sets bit 6; R9 summary same cycle; R10 pin lags one clock
      step(0, A_STAT, 0, 32'h0000_0040, 0);
      reg_addr = A_STAT; #1;
      chk("R9 summary immediate", reg_rdata, 32'h8000_0040);
      chk("R10 pin not yet low", {31'd0, irq_n}, 32'd1);
      step(0, A_STAT, 0, 0, 0);
      chk("R10 pin low next clock", {31'd0, irq_n}, 32'd0);
      check_all("R10");

      // R3 write 1 clears, write 0 keeps
      step(0, A_STAT, 0, 32'h1000_0080, 0);
      step(1, A_STAT, 32'h0000_0080, 0, 0);
      check_all("R3 clear one");
      reg_addr = A_STAT; #1;
      chk("R3 others kept", reg_rdata & 32'h7FFF_FFFF, 32'h1000_0040);
      step(1, A_STAT, 32'h0000_0000, 0, 0);
      check_all("R3 zero write");

      // R4 sealed flag survives a normal all-ones write
      step(0, A_STAT, 0, SEAL_M, 0);
      step(1, A_STAT, 32'hFFFF_FFFF, 0, 0);
      reg_addr = A_STAT; #1;
      chk("R4 sealed kept", reg_rdata & 32'h7FFF_FFFF, SEAL_M);
      check_all("R4");

      // R5 test mode loads; R7 unused positions stay zero
      step(1, A_STAT, 32'hFFFF_FFFF, 0, 1);
      reg_addr = A_STAT; #1;
      chk("R5 R7 test load", reg_rdata & 32'h7FFF_FFFF, BODY);
      step(1, A_STAT, 32'h0000_0000, 0, 1);
      check_all("R5 test clear");

      // R6 set wins over a same-cycle clear
      step(0, A_STAT, 0, 32'h4000_0000, 0);
      step(1, A_STAT, 32'h4000_0000, 32'h4000_0000, 0);
      reg_addr = A_STAT; #1;
      chk("R6 collision", reg_rdata & 32'h4000_0000, 32'h4000_0000);
      step(1, A_STAT, 32'h0000_0000, 32'h0000_0800, 1);
      check_all("R6 test collision");

      // R7 events on unused positions ignored
      step(0, A_STAT, 0, 32'h0004_703F, 0);
      check_all("R7 unused events");

      // R2 stray offset: reads zero, writes ignored
      step(1, 8'h14, 32'hFFFF_FFFF, 0, 0);
      reg_addr = 8'h14; #1;
      chk("R2 stray read", reg_rdata, 32'h0);
      check_all("R2 stray write");

      // R10 global gate off keeps pin high
      step(1, A_MASK, 32'h7FFF_FFFF, 0, 0);
      step(0, A_STAT, 0, 0, 0);
      check_all("R10 gate off");

      // Constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0]  a;
         logic [31:0] ev;
         int unsigned r;
         r = $urandom % 4;
         a = (r == 1) ? A_MASK : (r == 3) ? 8'($urandom) : A_STAT;
         ev = $urandom & $urandom & $urandom;
         step(1'($urandom % 2), a, $urandom, ev, ($urandom % 8) == 0);
         check_all("R2 R3 R6 R9 R10 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule